// File: doc/BRIEF.md
# Square-String Recognizer (Linear Cell Array)

The block watches a stream of symbols coming from a host, one symbol per clock. After each accepted symbol it reports whether everything received since the last clear has the form ww: some string w followed by an exact copy of w. The empty prefix counts as a match. The answer is available combinationally in the same cycle the symbol is presented. It can therefore be used as a live flag by whatever logic produces the stream.

The design is a linear chain of identical cells. Each cell has a top slot and a bottom slot, and each slot has its own valid bit. Symbols move away from the host through registered forward links. Each cell sends one record back toward the host over an unregistered link, and that record does two jobs.

- When the new prefix length is odd, the record carries a symbol that has run off the end of the bottom row back to the head of the array. The head holds it and inserts it into the top row on the next symbol.
- When the new prefix length is even, the record carries an AND-accumulated equality flag.

Capacity is set by the cell-count parameter: up to twice that many symbols. One more symbol raises a sticky overflow flag.

Top module: `sqr_match_top`

## Requirements
- R1: After reset, and in every cycle that follows a clear, the array holds no symbols. In that state, with no symbol presented, match_o is 1 and ovf_o is 0.
- R2: In a cycle with sym_valid_i=1, clr_i=0 and ovf_o=0, the symbol is accepted at the next rising edge. In that same cycle, match_o already gives the result for the prefix that includes sym_i.
- R3: When the accepted prefix has odd length, match_o is 0.
- R4: When the accepted prefix has even length 2k, with 2k no more than 2*N_CELLS, match_o is 1 exactly when s[i]==s[i+k] for every i<k. Here s[0] is the first symbol after the clear.
- R5: In a cycle with sym_valid_i=0 and clr_i=0, nothing is accepted. match_o shows the result of the last accepted prefix, or 1 if nothing has been accepted since the clear.
- R6: clr_i is synchronous and takes priority over sym_valid_i. A symbol presented together with clr_i is discarded. During the clear cycle, match_o still shows the previous result.
- R7: Accepting symbol number 2*N_CELLS+1 gives match_o=0 in that cycle and sets ovf_o from the next cycle on. ovf_o stays set until a clear. While ovf_o=1, symbols are ignored and match_o is 0.
- R8: A prefix of exactly 2*N_CELLS symbols, filling every slot, is judged correctly, both as a match and as a mismatch.
- R9: After a clear, a new string is judged without any influence from symbols received before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear: empties the array |
| sym_valid_i | input | 1 | A symbol is presented this cycle |
| sym_i | input | SYM_W | Symbol value |
| match_o | output | 1 | Prefix has the form ww (same cycle when a symbol is presented) |
| ovf_o | output | 1 | Sticky: more than 2*N_CELLS symbols were offered |

## Verification
The hardest situation to reach is a completely full array. In that state the symbol recirculated on an odd round finds no cell with an empty top slot, and that is the only way the overflow path is taken. The stimulus gets there by planting a square string of exactly 2*N_CELLS symbols and then continuing to feed symbols. The same filled state also checks R8 at the last cell of the chain. Coincidental matches and near-misses at every even length come from random strings over a two-letter alphabet, and the model recomputes the square test from a queue after every symbol.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  // Kind of round about to happen, from the parity of the current prefix
  typedef enum logic {
    ROUND_EVEN = 1'b0,  // next prefix length even: compare
    ROUND_ODD  = 1'b1   // next prefix length odd: recirculate
  } round_e;
endpackage

// File: rtl/sqr_cell.sv
module sqr_cell #(
  parameter int SYM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  sqr_pkg::round_e      rnd,
  input  logic [SYM_W-1:0]     l_top,
  input  logic                 l_top_v,
  input  logic [SYM_W-1:0]     l_bot,
  input  logic                 l_bot_v,
  input  logic [SYM_W:0]       back_in,
  output logic [SYM_W:0]       back_out,
  output logic [SYM_W-1:0]     top_q,
  output logic                 top_v_q,
  output logic [SYM_W-1:0]     bot_q,
  output logic                 bot_v_q
);
  import sqr_pkg::*;

  logic             odd;
  logic [SYM_W-1:0] top_d;
  logic             top_v_d;
  logic             bot_v_d;
  logic             pair_ok;

  // Next-state and return-link logic
  always_comb begin
    odd     = (rnd == ROUND_ODD);
    // top row moves only on even rounds
    top_d   = odd ? top_q   : l_top;
    top_v_d = odd ? top_v_q : l_top_v;
    // a bottom symbol is kept only where its top partner exists
    bot_v_d = l_bot_v & top_v_d;
    pair_ok = top_v_d ? (l_bot_v && (top_d == l_bot)) : 1'b1;
    if (odd) begin
      // first cell with an empty top turns the incoming bottom symbol back
      if (!top_v_q && l_bot_v) back_out = {l_bot, 1'b1};
      else                     back_out = back_in;
    end else begin
      back_out = {back_in[SYM_W:1], pair_ok & back_in[0]};
    end
  end

  // Slot registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      top_v_q <= 1'b0;
      bot_q   <= '0;
      bot_v_q <= 1'b0;
    end else if (clr) begin
      top_v_q <= 1'b0;
      bot_v_q <= 1'b0;
    end else if (adv) begin
      top_q   <= top_d;
      top_v_q <= top_v_d;
      bot_q   <= l_bot;
      bot_v_q <= bot_v_d;
    end
  end
endmodule

// File: rtl/sqr_head.sv
module sqr_head #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic [SYM_W:0]   back_in,
  output sqr_pkg::round_e  rnd,
  output logic             adv,
  output logic [SYM_W-1:0] pend_q,
  output logic             pend_v_q,
  output logic             match_o,
  output logic             ovf_q
);
  import sqr_pkg::*;

  logic par_q;    // 1: accepted prefix length is odd
  logic match_q;
  logic live;
  logic ovf_hit;

  always_comb begin
    rnd     = par_q ? ROUND_EVEN : ROUND_ODD;
    adv     = vld & ~clr & ~ovf_q;
    live    = (rnd == ROUND_EVEN) & back_in[0];
    // odd round with no empty top anywhere: the array is full
    ovf_hit = adv & (rnd == ROUND_ODD) & ~back_in[0];
    match_o = adv ? live : match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      match_q  <= 1'b1;
      ovf_q    <= 1'b0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (clr) begin
      par_q    <= 1'b0;
      match_q  <= 1'b1;
      ovf_q    <= 1'b0;
      pend_v_q <= 1'b0;
    end else if (adv) begin
      par_q   <= ~par_q;
      match_q <= live;
      if (ovf_hit) ovf_q <= 1'b1;
      if (rnd == ROUND_ODD) begin
        pend_q   <= back_in[SYM_W:1];
        pend_v_q <= back_in[0];
      end
    end
  end
endmodule

// File: rtl/sqr_match_top.sv
module sqr_match_top #(
  parameter int N_CELLS = 8,
  parameter int SYM_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             match_o,
  output logic             ovf_o
);
  import sqr_pkg::*;

  localparam int LINK_W = SYM_W + 1;

  round_e            rnd;
  logic              adv;
  logic [SYM_W-1:0]  pend;
  logic              pend_v;

  logic [SYM_W-1:0]  top_w   [N_CELLS];
  logic              top_v_w [N_CELLS];
  logic [SYM_W-1:0]  bot_w   [N_CELLS];
  logic              bot_v_w [N_CELLS];
  logic [LINK_W-1:0] back_w  [N_CELLS+1];

  // Far end of the return chain: nothing in odd rounds, a 1 in even rounds
  assign back_w[N_CELLS] = (rnd == ROUND_EVEN) ? {{SYM_W{1'b0}}, 1'b1} : '0;

  sqr_head #(.SYM_W(SYM_W)) u_head (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_i),
    .vld      (sym_valid_i),
    .back_in  (back_w[0]),
    .rnd      (rnd),
    .adv      (adv),
    .pend_q   (pend),
    .pend_v_q (pend_v),
    .match_o  (match_o),
    .ovf_q    (ovf_o)
  );

  for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
    logic [SYM_W-1:0] lt, lb;
    logic             ltv, lbv;
    if (j == 0) begin : g_first
      assign lt  = pend;
      assign ltv = pend_v;
      assign lb  = sym_i;
      assign lbv = sym_valid_i;
    end else begin : g_next
      assign lt  = top_w[j-1];
      assign ltv = top_v_w[j-1];
      assign lb  = bot_w[j-1];
      assign lbv = bot_v_w[j-1];
    end
    sqr_cell #(.SYM_W(SYM_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_i),
      .adv      (adv),
      .rnd      (rnd),
      .l_top    (lt),
      .l_top_v  (ltv),
      .l_bot    (lb),
      .l_bot_v  (lbv),
      .back_in  (back_w[j+1]),
      .back_out (back_w[j]),
      .top_q    (top_w[j]),
      .top_v_q  (top_v_w[j]),
      .bot_q    (bot_w[j]),
      .bot_v_q  (bot_v_w[j])
    );
  end

  // Last cell's forward outputs have no neighbour
  logic tail_unused;
  assign tail_unused = ^{top_w[N_CELLS-1], top_v_w[N_CELLS-1],
                         bot_w[N_CELLS-1], bot_v_w[N_CELLS-1]};
endmodule

// File: rtl/sqr_chk.sv
module sqr_chk #(
  parameter int N_CELLS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic clr_i,
  input logic sym_valid_i,
  input logic match_o,
  input logic ovf_o
);
  localparam int LEN_W = $clog2(2*N_CELLS + 2) + 1;

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            len_q <= '0;
    else if (clr_i)                        len_q <= '0;
    else if (sym_valid_i && !ovf_o)        len_q <= len_q + 1'b1;
  end

  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!ovf_o && (sym_valid_i || match_o)));

  // R3
  odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_i && !clr_i && !ovf_o && !len_q[0]) |-> !match_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid_i && !clr_i) |=> (sym_valid_i || clr_i || $stable(match_o)));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);

  // R7
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> !match_o);

  // R7
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> (len_q == LEN_W'(2*N_CELLS + 1)));
endmodule

bind sqr_match_top sqr_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .sym_valid_i (sym_valid_i),
  .match_o     (match_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_sqr_match_top.sv
`timescale 1ns/1ps
module tb_sqr_match_top;
  localparam int N = 8;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_i = 1'b0;
  logic         sym_valid_i = 1'b0;
  logic [W-1:0] sym_i = '0;
  logic         match_o, ovf_o;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] q[$];
  bit           m_ovf = 0;
  bit           m_last = 1;
  bit           just_cleared = 1;

  always #10 clk = ~clk;

  sqr_match_top #(.N_CELLS(N), .SYM_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sym_valid_i(sym_valid_i),
    .sym_i(sym_i), .match_o(match_o), .ovf_o(ovf_o));

  function automatic bit is_square();
    int n = q.size();
    int k = n / 2;
    if (n % 2 != 0) return 0;
    for (int i = 0; i < k; i++) if (q[i] != q[i+k]) return 0;
    return 1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (len=%0d)", tag, act, exp, q.size());
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [W-1:0] s);
    bit    exp;
    bit    ovf_now;
    bit    ovf_next;
    string tag;
    @(negedge clk);
    clr_i = c; sym_valid_i = v; sym_i = s;
    #5;
    ovf_now  = m_ovf;
    ovf_next = m_ovf;
    if (c) begin
      exp = m_last; tag = "R6";
    end else if (v && !m_ovf) begin
      q.push_back(s);
      if (q.size() > 2*N) begin
        exp = 0; tag = "R7"; ovf_next = 1;
      end else if (q.size() % 2 == 1) begin
        exp = 0; tag = "R3";
      end else begin
        exp = is_square();
        tag = (q.size() == 2*N) ? "R8" : "R2,R4";
      end
      m_last = exp;
    end else if (v) begin
      exp = 0; tag = "R7";
    end else begin
      exp = m_last; tag = just_cleared ? "R1" : "R5";
    end
    check({tag, " match"}, match_o, exp);
    check({tag, " ovf"}, ovf_o, ovf_now);
    if (c) begin
      q.delete(); m_last = 1; m_ovf = 0; just_cleared = 1;
    end else begin
      m_ovf = ovf_next;
      if (v) just_cleared = 0;
    end
  endtask

  task automatic plant(input int k, input int alpha);
    logic [W-1:0] w[$];
    for (int i = 0; i < k; i++) w.push_back(W'($urandom_range(0, alpha)));
    for (int i = 0; i < k; i++) step(0, 1, w[i]);
    for (int i = 0; i < k; i++) step(0, 1, w[i]);
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty array after reset
    step(0, 0, 0);
    step(0, 0, 0);

    // Planted squares of several lengths, with idle gaps (R4, R5)
    for (int k = 1; k <= 4; k++) begin
      step(1, 0, 0);
      plant(k, 3);
      step(0, 0, 0);
      step(0, 1, 8'h5A);
      step(0, 0, 0);
    end

    // Random binary strings; clear with a symbol presented (R6, R9)
    for (int t = 0; t < 20; t++) begin
      step(1, 1, W'($urandom_range(0, 1)));
      step(0, 0, 0);
      for (int i = 0; i < 2*N; i++) step(0, 1, W'($urandom_range(0, 1)));
    end

    // Full-capacity mismatch (R8)
    step(1, 0, 0);
    for (int i = 0; i < 2*N - 1; i++) step(0, 1, W'(i));
    step(0, 1, 8'hFF);

    // Full-capacity square, then overflow (R8, R7)
    step(1, 0, 0);
    plant(N, 255);
    step(0, 0, 0);
    step(0, 1, 8'h11);
    step(0, 1, 8'h22);
    step(0, 0, 0);
    step(0, 1, 8'h33);
    step(1, 0, 0);
    step(0, 0, 0);

    // R9: fresh square after the overflowed run
    plant(2, 255);
    step(0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule